// File: doc/BRIEF.md
# Dual-Path Alternating Clock Root Slice

This block derives one output clock from a choice of eight source clocks. Two identical paths, A and B, each have their own source selector, a glitch-free clock gate and a pre-divider. A glitch-free 2:1 switch picks one of the two paths, and a shared post-divider follows it. An output gate comes last. A simple register port, clocked by the control clock, accepts writes that carry a source select, two divider values and an output gate enable. A combinational readback word shows the state of the slice.

A write never touches the path that is driving the output. Every accepted write loads the idle path, turns on that path's gate and then moves the output onto it. The old path is released on its own low phase. The new path is enabled only after that release has passed through two flops in the new path's clock domain. When the switch is done, the gate of the old path closes and the busy flag drops. A write that arrives while the busy flag is set is dropped.

If the newly selected source is not toggling, the switch cannot finish: busy stays set and the output stays low until the source starts. The core variant (`HAS_PREDIV = 0`) has no pre-dividers.

Top module: `clk_root_slice`

## Requirements
- R1: After reset, readback equals 0x1000_0000. Path A is active (bit 29 = 0), both selects are 0, both divider values are 0, the output gate enable (bit 28) is 1 and busy (bit 31) is 0. The output runs at the period of source 0.
- R2: Each accepted write loads the currently idle path and makes it the active one, so writes alternate between the paths; the first write after reset loads path B. Readback shows the path A select in bits 26:24, the path B select in bits 10:8 and the active path in bit 29 (0 = A, 1 = B).
- R3: Busy (bit 31) reads 1 from the cycle after an accepted write until the switch completes. A write made while busy is 1 changes no field and does not advance the alternation.
- R4: After a switch completes, the output period is the period of source k × (pre + 1) × (post + 1), where k is the select of the active path. Only one path drives the output at any time, and the idle path is released whenever busy is 0.
- R5: Writing the same select value twice in a row leaves both select fields at that value.
- R6: A pre-divider value N (3 bits, taken from the write and stored per path) divides the path's clock by N + 1; N = 7 divides by 8. Bits 18:16 show the active path's value.
- R7: A post-divider value N (3 bits, bits 2:0 of readback) divides the switched clock by N + 1.
- R8: With the gate enable written as 0, the output is held low, and bit 28 reads 0.
- R9: If the newly selected source is stopped, busy stays 1 and the output has no edges. Once that source runs again, the switch completes at the new period.
- R10: In the core variant, the pre-divider value has no effect on the output period.
- R11: A divider loads a new value only at the end of its current output period. The first full period after a switch already shows the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock for the register port |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_clk_i | input | NUM_SRC | Source clocks, index = select value |
| wr_en_i | input | 1 | Write strobe, one control cycle |
| wr_sel_i | input | SEL_W | Source select for the idle path |
| wr_pre_div_i | input | DIV_W | Pre-divider value N for the idle path |
| wr_post_div_i | input | DIV_W | Post-divider value N |
| wr_gate_en_i | input | 1 | Output gate enable |
| rd_data_o | output | 32 | Readback word |
| clk_o | output | 1 | Divided, gated output clock |

## Verification
The bench builds two instances from the same eight running source clocks. One uses the default parameters (eight sources, 3-bit dividers, pre-dividers present). This instance covers alternation, the ignored write during busy, both dividers up to the maximum ratio, the output gate and the stall on a stopped source. The second instance is the core variant with `HAS_PREDIV = 0`. It shows that the pre-divider field is inert there, and it runs the post-divider at divide-by-8 with no pre-divider in front. Because each source has a distinct period, every measured output period identifies which source and which divider ratios are in effect.

// File: rtl/crs_pkg.sv
`timescale 1ns/1ps
package crs_pkg;
  localparam int unsigned NUM_SRC      = 8;
  localparam int unsigned DIV_W        = 3;
  localparam int unsigned NUM_PATH     = 2;
  // readback field positions
  localparam int unsigned RB_POST_LSB  = 0;
  localparam int unsigned RB_SEL_B_LSB = 8;
  localparam int unsigned RB_PRE_LSB   = 16;
  localparam int unsigned RB_SEL_A_LSB = 24;
  localparam int unsigned RB_GATE_BIT  = 28;
  localparam int unsigned RB_ACT_BIT   = 29;
  localparam int unsigned RB_BUSY_BIT  = 31;

  typedef enum logic {
    PATH_A = 1'b0,
    PATH_B = 1'b1
  } path_e;
endpackage

// File: rtl/crs_clk_div.sv
`timescale 1ns/1ps
module crs_clk_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             clk_o
);
  logic [DIV_W-1:0] n_q, cnt_q;
  logic             ph_q;
  logic             wrap;

  assign wrap = (cnt_q == n_q);

  // new ratio is picked up only on the last input cycle of a period
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q   <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (wrap) begin
      n_q   <= div_i;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      ph_q  <= 1'b0;
    end
  end

  assign clk_o = (n_q == '0) ? clk_i : ph_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= n_q) else $error("divider count past limit"); // R6

  AST_DIV_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(n_q) |-> $past(cnt_q) == $past(n_q)) else $error("ratio changed mid-period"); // R11
endmodule

// File: rtl/crs_src_path.sv
`timescale 1ns/1ps
module crs_src_path #(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned SEL_W      = 3,
  parameter int unsigned DIV_W      = 3,
  parameter bit          HAS_PREDIV = 1'b1,
  parameter bit          GATE_RST   = 1'b0
) (
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               rst_ni,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               gate_req_i,
  input  logic [DIV_W-1:0]   pre_div_i,
  output logic               path_clk_o
);
  logic raw_clk, gate_q, gated_clk;

  assign raw_clk = src_clk_i[sel_i];

  // gate enable changes only while the source is low
  always_ff @(negedge raw_clk or negedge rst_ni) begin
    if (!rst_ni) gate_q <= GATE_RST;
    else         gate_q <= gate_req_i;
  end

  assign gated_clk = raw_clk & gate_q;

  if (HAS_PREDIV) begin : g_pre
    crs_clk_div #(.DIV_W(DIV_W)) u_pre (
      .clk_i  (gated_clk),
      .rst_ni (rst_ni),
      .div_i  (pre_div_i),
      .clk_o  (path_clk_o)
    );
  end else begin : g_nopre
    assign path_clk_o = gated_clk;
  end
endmodule

// File: rtl/crs_glitchless_mux.sv
`timescale 1ns/1ps
module crs_glitchless_mux (
  input  logic [1:0] clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  output logic       clk_o,
  output logic [1:0] en_o
);
  for (genvar p = 0; p < 2; p++) begin : g_leg
    logic req, s1_q, s2_q, en_q;

    assign req = (sel_i == 1'(p)) & ~en_o[1-p];

    always_ff @(posedge clk_i[p] or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'(p == 0);
        s2_q <= 1'(p == 0);
      end else begin
        s1_q <= req;
        s2_q <= s1_q;
      end
    end

    // release and enable on this leg's low phase
    always_ff @(negedge clk_i[p] or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'(p == 0);
      else         en_q <= s2_q;
    end

    assign en_o[p] = en_q;
  end

  assign clk_o = |(clk_i & en_o);
endmodule

// File: rtl/clk_root_slice.sv
`timescale 1ns/1ps
module clk_root_slice
  import crs_pkg::*;
#(
  parameter int unsigned NUM_SRC    = crs_pkg::NUM_SRC,
  parameter int unsigned DIV_W      = crs_pkg::DIV_W,
  parameter bit          HAS_PREDIV = 1'b1,
  localparam int unsigned SEL_W     = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic               wr_en_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [DIV_W-1:0]   wr_pre_div_i,
  input  logic [DIV_W-1:0]   wr_post_div_i,
  input  logic               wr_gate_en_i,
  output logic [31:0]        rd_data_o,
  output logic               clk_o
);
  path_e                              act_q, idle;
  logic                               busy_q, gate_en_q, wr_ok, done;
  logic [NUM_PATH-1:0][SEL_W-1:0]     sel_q;
  logic [NUM_PATH-1:0][DIV_W-1:0]     pre_q;
  logic [DIV_W-1:0]                   post_q;
  logic [NUM_PATH-1:0]                gate_req, path_clk, en_raw, en_m_q, en_s_q;
  logic                               mux_clk, div_clk, out_g_q;

  assign idle  = path_e'(~act_q);
  assign wr_ok = wr_en_i & ~busy_q;
  assign done  = busy_q & en_s_q[act_q] & ~en_s_q[idle];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q     <= PATH_A;
      busy_q    <= 1'b0;
      sel_q     <= '0;
      pre_q     <= '0;
      post_q    <= '0;
      gate_en_q <= 1'b1;
    end else if (wr_ok) begin
      sel_q[idle] <= wr_sel_i;
      pre_q[idle] <= wr_pre_div_i;
      post_q      <= wr_post_div_i;
      gate_en_q   <= wr_gate_en_i;
      act_q       <= idle;
      busy_q      <= 1'b1;
    end else if (done) begin
      busy_q <= 1'b0;
    end
  end

  // path enables brought back into the control domain
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_m_q <= 2'b01;
      en_s_q <= 2'b01;
    end else begin
      en_m_q <= en_raw;
      en_s_q <= en_m_q;
    end
  end

  for (genvar p = 0; p < NUM_PATH; p++) begin : g_path
    // old path keeps its clock until the switch is over
    assign gate_req[p] = (act_q == path_e'(p)) | busy_q;

    crs_src_path #(
      .NUM_SRC    (NUM_SRC),
      .SEL_W      (SEL_W),
      .DIV_W      (DIV_W),
      .HAS_PREDIV (HAS_PREDIV),
      .GATE_RST   (p == 0)
    ) u_path (
      .src_clk_i  (src_clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (sel_q[p]),
      .gate_req_i (gate_req[p]),
      .pre_div_i  (pre_q[p]),
      .path_clk_o (path_clk[p])
    );
  end

  crs_glitchless_mux u_mux (
    .clk_i  (path_clk),
    .rst_ni (rst_ni),
    .sel_i  (act_q),
    .clk_o  (mux_clk),
    .en_o   (en_raw)
  );

  crs_clk_div #(.DIV_W(DIV_W)) u_post (
    .clk_i  (mux_clk),
    .rst_ni (rst_ni),
    .div_i  (post_q),
    .clk_o  (div_clk)
  );

  always_ff @(negedge div_clk or negedge rst_ni) begin
    if (!rst_ni) out_g_q <= 1'b1;
    else         out_g_q <= gate_en_q;
  end

  assign clk_o = div_clk & out_g_q;

  always_comb begin
    rd_data_o                             = '0;
    rd_data_o[RB_SEL_A_LSB +: SEL_W]      = sel_q[PATH_A];
    rd_data_o[RB_SEL_B_LSB +: SEL_W]      = sel_q[PATH_B];
    rd_data_o[RB_PRE_LSB +: DIV_W]        = pre_q[act_q];
    rd_data_o[RB_POST_LSB +: DIV_W]       = post_q;
    rd_data_o[RB_GATE_BIT]                = gate_en_q;
    rd_data_o[RB_ACT_BIT]                 = act_q;
    rd_data_o[RB_BUSY_BIT]                = busy_q;
  end

  AST_BUSY_WR_DROPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && wr_en_i |=> (sel_q == $past(sel_q)) && (act_q == $past(act_q)))
    else $error("write accepted while busy"); // R3

  AST_WR_ALTERNATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !busy_q |=> busy_q && (act_q != $past(act_q)))
    else $error("write did not move to idle path"); // R2

  AST_PATH_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_raw)) else $error("both paths enabled"); // R4

  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !en_s_q[idle]) else $error("idle path still enabled"); // R4
endmodule

// File: tb/clk_root_slice_tb_top.sv
`timescale 1ns/1ps
module clk_root_slice_tb_top;
  localparam int NSRC = 8;

  typedef struct {
    string       req;
    int          kind;    // 0 readback, 1 period, 2 no edges
    int          dut;
    logic [31:0] exp_rd;
    logic [31:0] mask;
    real         exp_per;
  } item_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  wire  [NSRC-1:0] src_clk;
  logic [NSRC-1:0] src_run = '1;

  logic [1:0]  wr_en = '0;
  logic [2:0]  wr_sel [2];
  logic [2:0]  wr_pre [2];
  logic [2:0]  wr_post [2];
  logic [1:0]  wr_gate = '1;
  logic [31:0] rd [2];
  logic [1:0]  clk_o;

  int      checks = 0, errors = 0;
  bit      finished = 0, mon_busy = 0;
  item_t   sb_q[$];
  realtime last_t [2], prev_t [2];
  int      edges [2];

  always #5 clk_i = ~clk_i;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic c = 1'b0;
    always begin
      #(3.0 + k);
      if (src_run[k]) c = ~c;
    end
    assign src_clk[k] = c;
  end

  clk_root_slice dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_clk_i(src_clk), .wr_en_i(wr_en[0]),
    .wr_sel_i(wr_sel[0]), .wr_pre_div_i(wr_pre[0]), .wr_post_div_i(wr_post[0]),
    .wr_gate_en_i(wr_gate[0]), .rd_data_o(rd[0]), .clk_o(clk_o[0]));

  clk_root_slice #(.HAS_PREDIV(1'b0)) dut_core_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_clk_i(src_clk), .wr_en_i(wr_en[1]),
    .wr_sel_i(wr_sel[1]), .wr_pre_div_i(wr_pre[1]), .wr_post_div_i(wr_post[1]),
    .wr_gate_en_i(wr_gate[1]), .rd_data_o(rd[1]), .clk_o(clk_o[1]));

  always @(posedge clk_o[0]) begin prev_t[0] = last_t[0]; last_t[0] = $realtime; edges[0]++; end
  always @(posedge clk_o[1]) begin prev_t[1] = last_t[1]; last_t[1] = $realtime; edges[1]++; end

  function automatic logic [31:0] rb(int sa, int sb, int pre, int post, int gate, int act, int busy);
    logic [31:0] v = '0;
    v[26:24] = 3'(sa);  v[10:8] = 3'(sb);  v[18:16] = 3'(pre);
    v[2:0]   = 3'(post); v[28] = 1'(gate); v[29] = 1'(act); v[31] = 1'(busy);
    return v;
  endfunction

  // monitor: pops expectations and compares against what the design shows
  initial begin
    forever begin
      @(negedge clk_i);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        mon_busy = 1;
        checks++;
        case (it.kind)
          0: if ((rd[it.dut] & it.mask) !== (it.exp_rd & it.mask)) begin
               errors++;
               $display("FAIL %s dut%0d readback act=%h exp=%h", it.req, it.dut,
                        rd[it.dut] & it.mask, it.exp_rd & it.mask);
             end
          1: begin
               real per;
               per = last_t[it.dut] - prev_t[it.dut];
               if (per < it.exp_per - 0.01 || per > it.exp_per + 0.01) begin
                 errors++;
                 $display("FAIL %s dut%0d period act=%0.2f exp=%0.2f", it.req, it.dut, per, it.exp_per);
               end
             end
          default: begin
               int c0;
               c0 = edges[it.dut];
               repeat (50) @(negedge clk_i);
               if (edges[it.dut] != c0) begin
                 errors++;
                 $display("FAIL %s dut%0d edges act=%0d exp=0", it.req, it.dut, edges[it.dut] - c0);
               end
             end
        endcase
        mon_busy = 0;
      end
    end
  end

  task automatic push(string req, int kind, int dut, logic [31:0] e, logic [31:0] m, real per);
    item_t it;
    it.req = req; it.kind = kind; it.dut = dut; it.exp_rd = e; it.mask = m; it.exp_per = per;
    sb_q.push_back(it);
  endtask

  task automatic flush();
    do @(negedge clk_i); while (sb_q.size() != 0 || mon_busy);
  endtask

  task automatic wr(int d, int sel, int pre, int post, int gate);
    @(negedge clk_i);
    wr_en[d] = 1'b1; wr_sel[d] = 3'(sel); wr_pre[d] = 3'(pre);
    wr_post[d] = 3'(post); wr_gate[d] = 1'(gate);
    @(negedge clk_i);
    wr_en[d] = 1'b0;
  endtask

  task automatic settle(int d, string req);
    int n = 0;
    while (rd[d][31] && n < 3000) begin @(negedge clk_i); n++; end
    if (rd[d][31]) begin
      checks++; errors++;
      $display("FAIL %s dut%0d busy act=1 exp=0", req, d);
    end
    repeat (80) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    wr_sel[0] = '0; wr_sel[1] = '0; wr_pre[0] = '0; wr_pre[1] = '0;
    wr_post[0] = '0; wr_post[1] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (60) @(negedge clk_i);

    // R1 reset state
    push("R1", 0, 0, 32'h1000_0000, '1, 0);
    push("R1", 0, 1, 32'h1000_0000, '1, 0);
    push("R1", 1, 0, 0, 0, 6.0);
    flush();

    // R2 R3 first write goes to B
    wr(0, 3, 0, 0, 1);
    push("R3", 0, 0, rb(0, 3, 0, 0, 1, 1, 1), '1, 0);
    flush();
    settle(0, "R3");
    push("R2", 0, 0, rb(0, 3, 0, 0, 1, 1, 0), '1, 0);
    push("R4", 1, 0, 0, 0, 12.0);
    flush();

    // R5 same select again lands in A
    wr(0, 3, 0, 0, 1);
    settle(0, "R5");
    push("R5", 0, 0, rb(3, 3, 0, 0, 1, 0, 0), '1, 0);
    push("R4", 1, 0, 0, 0, 12.0);
    flush();

    // R3 second write while busy dropped; R6 pre-divide by 3
    wr(0, 1, 2, 0, 1);
    wr(0, 6, 0, 0, 1);
    settle(0, "R3");
    push("R3", 0, 0, rb(3, 1, 2, 0, 1, 1, 0), '1, 0);
    push("R6", 1, 0, 0, 0, 24.0);
    flush();

    // R7 R11 post-divide by 2
    wr(0, 1, 0, 1, 1);
    settle(0, "R7");
    push("R7", 0, 0, rb(1, 1, 0, 1, 1, 0, 0), '1, 0);
    push("R11", 1, 0, 0, 0, 16.0);
    flush();

    // R8 output gate off
    wr(0, 2, 0, 0, 0);
    settle(0, "R8");
    push("R8", 0, 0, rb(1, 2, 0, 0, 0, 1, 0), '1, 0);
    push("R8", 2, 0, 0, 0, 0);
    flush();
    wr(0, 2, 0, 0, 1);
    settle(0, "R8");
    push("R8", 1, 0, 0, 0, 10.0);
    flush();

    // R9 stopped source stalls the switch
    src_run[7] = 1'b0;
    wr(0, 7, 0, 0, 1);
    repeat (100) @(negedge clk_i);
    push("R9", 0, 0, 32'hA000_0000, 32'hA000_0000, 0);
    push("R9", 2, 0, 0, 0, 0);
    flush();
    src_run[7] = 1'b1;
    settle(0, "R9");
    push("R9", 0, 0, rb(2, 7, 0, 0, 1, 1, 0), '1, 0);
    push("R9", 1, 0, 0, 0, 20.0);
    flush();

    // R6 maximum pre ratio
    wr(0, 0, 7, 0, 1);
    settle(0, "R6");
    push("R6", 1, 0, 0, 0, 48.0);
    flush();

    // R10 core variant ignores pre field
    wr(1, 4, 3, 0, 1);
    settle(1, "R10");
    push("R10", 0, 1, rb(0, 4, 3, 0, 1, 1, 0), '1, 0);
    push("R10", 1, 1, 0, 0, 14.0);
    flush();

    // R7 R11 maximum post ratio on core
    wr(1, 0, 0, 7, 1);
    settle(1, "R11");
    push("R11", 1, 1, 0, 0, 48.0);
    flush();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule